// File: doc/BRIEF.md
# Prioritized Power-State Trigger Controller

This block is the decision core of a power-management controller. Each clock it looks at a set of trigger requests: fault flags, on and off requests, two wake pins, two sleep controls and four self-clearing register commands. Out of the triggers that are legal in the present power state, it picks the one with the lowest ID, which is the highest priority. It then moves to that trigger's destination state and starts the matching power sequence by sending a one-cycle start pulse with a sequence code. An external rail sequencer returns a done pulse when the sequence is finished.

Each trigger row has two flags. An immediate row may abort a sequence that is still running. A re-entrant row keeps the current state. A row can move to another state, stay in the same state and run a recovery sequence, or just run a function.

After a fault shutdown the controller counts its restart attempts. Once the count reaches a programmable threshold, it halts until reset. Enabling bus CRC sets a sticky flag and holds the secondary bus disabled for a fixed time derived from the clock frequency.

Top module: `pwr_trig_ctrl`

## Requirements
- R1: After reset the state is STANDBY and all outputs are zero: no start pulse, not busy, CRC flag and bus hold low, recovery count zero. State codes: STANDBY 0, ACTIVE 1, MCU_ONLY 2, RETENTION 3, SAFE 4, SAFE_RECOVERY 5, HALTED 6, SOC_ERROR 7, LOW_POWER_STANDBY 8.
- R2: Trigger selection happens on each clock edge. Among the requested triggers that are valid in the current state, the lowest ID wins. In the cycle after the inputs are sampled, the controller shows the new state, a one-cycle start pulse and the sequence code. The code output holds its value between starts. Sequence codes: severe safe 1, safe 2, orderly safe 3, to standby 4, active warm 5, SoC ESM 6, MCU warm 7, MCU ESM 8, SoC power error 9, self-test 10, CRC enable 11, to active 12, to MCU 13, to retention 14, update prep 15, to low-power standby 16.
- R3: The immediate rows go from STANDBY, ACTIVE, MCU_ONLY or RETENTION to SAFE, even while a sequence is still running:
  - ID 0, immediate shutdown, runs code 1.
  - ID 1, MCU power error, runs code 2.
  - ID 2, orderly shutdown, runs code 3.
- R4: Busy rises with every start and clears on the edge that samples done. Done has no effect when the controller is not busy. A non-immediate trigger is never taken while busy.
- R5: The re-entrant fault rows keep the current state:
  - In ACTIVE: ID 5 watchdog runs code 5, ID 6 MCU ESM runs code 5, ID 7 SoC ESM runs code 6.
  - In MCU_ONLY: ID 8 watchdog runs code 7, ID 9 MCU ESM runs code 8.
- R6: ID 10, SoC power error, is valid only in ACTIVE and goes to SOC_ERROR with code 9. ID 4, off request, goes to STANDBY with code 4 from ACTIVE, MCU_ONLY, RETENTION or SOC_ERROR.
- R7: Each sleep control reads high when either its pin or its register bit is high. The following rows are valid only when the destination differs from the current state:
  - To ACTIVE with code 12 from STANDBY, MCU_ONLY, RETENTION or low-power standby: ID 13 on request, ID 14 wake pin 1, ID 15 both sleep controls high.
  - To MCU_ONLY with code 13 from STANDBY, ACTIVE, RETENTION or low-power standby: ID 16 MCU-on request, ID 17 wake pin 2.
  - To MCU_ONLY with code 13 from ACTIVE or RETENTION: ID 18, sleep1 low and sleep2 high.
  - To RETENTION with code 14 from ACTIVE or MCU_ONLY: IDs 19 and 20, sleep2 low.
- R8: Any set sleep mask bit disables the sleep rows (IDs 15 and 18 to 20). Commands 0 and 3 (IDs 21 and 22) are valid only when both mask bits are set.
- R9: A pulse on a command input sets a pending bit, which the controller sees from the next cycle. A pending bit clears only when its row is taken. The command rows are:
  - Command 1 (ID 11, ACTIVE or MCU_ONLY): self-test, code 10.
  - Command 2 (ID 12, same states): CRC enable, code 11.
  - Command 3 (ID 22, same states): update prep, code 15.
  - Command 0 (ID 21, from STANDBY, ACTIVE or MCU_ONLY): goes to low-power standby with code 16.
  - Commands 1 to 3 leave the state unchanged.
- R10: Taking command 2 sets a sticky CRC flag. It also raises the bus-hold output for exactly CLK_HZ/1000*HOLD_MS cycles, starting in the start-pulse cycle. Taking command 2 again restarts the hold.
- R11: In SAFE, the first cycle that is not busy moves the controller to SAFE_RECOVERY and raises the recovery count, which saturates at its maximum. One cycle later the controller moves to HALTED if the count is at least the threshold, and to STANDBY otherwise. HALTED lasts until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imm_sd_i | input | 1 | Immediate shutdown request (ID 0) |
| mcu_pwr_err_i | input | 1 | MCU power error (ID 1) |
| orderly_sd_i | input | 1 | Orderly shutdown request (ID 2) |
| off_req_i | input | 1 | Off request (ID 4) |
| wdog_err_i | input | 1 | Watchdog error (IDs 5, 8) |
| esm_mcu_err_i | input | 1 | MCU error-monitor fault (IDs 6, 9) |
| esm_soc_err_i | input | 1 | SoC error-monitor fault (ID 7) |
| soc_pwr_err_i | input | 1 | SoC power error (ID 10) |
| on_req_i | input | 1 | On request (ID 13) |
| mcu_on_req_i | input | 1 | MCU-only on request (ID 16) |
| wake1_i | input | 1 | Wake pin 1 (ID 14) |
| wake2_i | input | 1 | Wake pin 2 (ID 17) |
| sleep_pin_i | input | 2 | Sleep control pins, bit 0 sleep1, bit 1 sleep2 |
| sleep_reg_i | input | 2 | Sleep control register bits, same order |
| sleep_mask_i | input | 2 | Sleep mask bits |
| cmd_set_i | input | 4 | Register command pulses, bit n is command n |
| recov_thr_i | input | RCW | Recovery attempt threshold |
| seq_done_i | input | 1 | Sequence done pulse from the sequencer |
| state_o | output | 4 | Current power state |
| seq_start_o | output | 1 | One-cycle sequence start pulse |
| seq_code_o | output | 5 | Code of the last started sequence |
| seq_busy_o | output | 1 | A sequence is in progress |
| crc_en_o | output | 1 | Sticky bus CRC enable |
| bus2_hold_o | output | 1 | Secondary bus held disabled |
| recov_cnt_o | output | RCW | Recovery attempt count |
| recov_halt_o | output | 1 | Recovery halted (HALTED state) |

## Verification
Every decision is registered once, so the state, start pulse, code, busy, CRC flag and hold output are all due one cycle after the sampled inputs. Inputs change on the falling edge, and a reference model steps at the rising edge and compares all outputs at the next falling edge. A command pulse takes two cycles to show an effect, because it first lands in its pending bit. The SAFE exit adds one cycle for SAFE_RECOVERY before HALTED or STANDBY appears. The directed checks count those cycles explicitly. The bus hold is measured by counting high cycles from the start pulse onward.

// File: rtl/pwr_trig_pkg.sv
package pwr_trig_pkg;

  localparam int unsigned NTRIG = 23;
  localparam int unsigned TW    = $clog2(NTRIG);

  typedef enum logic [3:0] {
    ST_STANDBY  = 4'd0,
    ST_ACTIVE   = 4'd1,
    ST_MCU      = 4'd2,
    ST_RET      = 4'd3,
    ST_SAFE     = 4'd4,
    ST_SAFE_REC = 4'd5,
    ST_HALT     = 4'd6,
    ST_SOC_ERR  = 4'd7,
    ST_LP_STBY  = 4'd8
  } pstate_e;

  typedef enum logic [4:0] {
    SQ_NONE       = 5'd0,
    SQ_SAFE_SEV   = 5'd1,
    SQ_SAFE       = 5'd2,
    SQ_SAFE_ORD   = 5'd3,
    SQ_TO_STBY    = 5'd4,
    SQ_ACT_WARM   = 5'd5,
    SQ_ESM_SOC    = 5'd6,
    SQ_MCU_WARM   = 5'd7,
    SQ_ESM_MCU    = 5'd8,
    SQ_PWR_SOC    = 5'd9,
    SQ_BIST       = 5'd10,
    SQ_CRC_EN     = 5'd11,
    SQ_TO_ACT     = 5'd12,
    SQ_TO_MCU     = 5'd13,
    SQ_TO_RET     = 5'd14,
    SQ_UPD_PREP   = 5'd15,
    SQ_TO_LP      = 5'd16
  } seq_e;

  typedef struct packed {
    logic    ok;
    logic    move;
    pstate_e dest;
    seq_e    code;
    logic    imm;
  } row_t;

  // One row of the fixed priority table, qualified by the present state.
  function automatic row_t row_info(input int unsigned id, input pstate_e s);
    row_t r;
    logic norm;
    norm   = s inside {ST_STANDBY, ST_ACTIVE, ST_MCU, ST_RET};
    r.ok   = 1'b0;
    r.move = 1'b0;
    r.dest = s;
    r.code = SQ_NONE;
    r.imm  = 1'b0;
    case (id)
      0:  begin r.ok = norm; r.move = 1'b1; r.dest = ST_SAFE; r.code = SQ_SAFE_SEV; r.imm = 1'b1; end
      1:  begin r.ok = norm; r.move = 1'b1; r.dest = ST_SAFE; r.code = SQ_SAFE;     r.imm = 1'b1; end
      2:  begin r.ok = norm; r.move = 1'b1; r.dest = ST_SAFE; r.code = SQ_SAFE_ORD; r.imm = 1'b1; end
      4:  begin r.ok = s inside {ST_ACTIVE, ST_MCU, ST_RET, ST_SOC_ERR};
                r.move = 1'b1; r.dest = ST_STANDBY; r.code = SQ_TO_STBY; end
      5, 6: begin r.ok = (s == ST_ACTIVE); r.code = SQ_ACT_WARM; end
      7:  begin r.ok = (s == ST_ACTIVE); r.code = SQ_ESM_SOC; end
      8:  begin r.ok = (s == ST_MCU); r.code = SQ_MCU_WARM; end
      9:  begin r.ok = (s == ST_MCU); r.code = SQ_ESM_MCU; end
      10: begin r.ok = (s == ST_ACTIVE); r.move = 1'b1; r.dest = ST_SOC_ERR; r.code = SQ_PWR_SOC; end
      11: begin r.ok = s inside {ST_ACTIVE, ST_MCU}; r.code = SQ_BIST; end
      12: begin r.ok = s inside {ST_ACTIVE, ST_MCU}; r.code = SQ_CRC_EN; end
      13, 14, 15: begin r.ok = s inside {ST_STANDBY, ST_MCU, ST_RET, ST_LP_STBY};
                r.move = 1'b1; r.dest = ST_ACTIVE; r.code = SQ_TO_ACT; end
      16, 17: begin r.ok = s inside {ST_STANDBY, ST_ACTIVE, ST_RET, ST_LP_STBY};
                r.move = 1'b1; r.dest = ST_MCU; r.code = SQ_TO_MCU; end
      18: begin r.ok = s inside {ST_ACTIVE, ST_RET}; r.move = 1'b1; r.dest = ST_MCU; r.code = SQ_TO_MCU; end
      19, 20: begin r.ok = s inside {ST_ACTIVE, ST_MCU}; r.move = 1'b1; r.dest = ST_RET; r.code = SQ_TO_RET; end
      21: begin r.ok = s inside {ST_STANDBY, ST_ACTIVE, ST_MCU};
                r.move = 1'b1; r.dest = ST_LP_STBY; r.code = SQ_TO_LP; end
      22: begin r.ok = s inside {ST_ACTIVE, ST_MCU}; r.code = SQ_UPD_PREP; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwr_trig_arb.sv
module pwr_trig_arb
  import pwr_trig_pkg::*;
#(
  parameter int unsigned N  = NTRIG,
  parameter int unsigned IW = $clog2(N)
) (
  input  pstate_e        state_i,
  input  logic           busy_i,
  input  logic [N-1:0]   req_i,
  output logic           win_o,
  output logic [IW-1:0]  id_o,
  output row_t           row_o
);

  row_t       rows [N];
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_row
    assign rows[g] = row_info(g, state_i);
    assign hit[g]  = req_i[g] & rows[g].ok & (rows[g].imm | ~busy_i);
  end

  // Lowest set index wins: scan from the bottom of the table upward.
  always_comb begin
    win_o = |hit;
    id_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) id_o = IW'(i);
    end
    row_o = rows[id_o];
  end

endmodule

// File: rtl/pwr_hold_tmr.sv
module pwr_hold_tmr #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned HOLD_MS = 2,
  parameter int unsigned CYC     = CLK_HZ / 1000 * HOLD_MS,
  parameter int unsigned CW      = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic active_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? CW'(CYC) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/pwr_recov_cnt.sv
module pwr_recov_cnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic [W-1:0] thr_i,
  output logic [W-1:0] cnt_o,
  output logic         reached_o
);

  logic [W-1:0] cnt_q;
  logic         cnt_en;

  assign cnt_en = inc_i & ~(&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign reached_o = (cnt_q >= thr_i);

endmodule

// File: rtl/pwr_trig_ctrl.sv
module pwr_trig_ctrl
  import pwr_trig_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned HOLD_MS = 2,
  parameter int unsigned RCW     = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           imm_sd_i,
  input  logic           mcu_pwr_err_i,
  input  logic           orderly_sd_i,
  input  logic           off_req_i,
  input  logic           wdog_err_i,
  input  logic           esm_mcu_err_i,
  input  logic           esm_soc_err_i,
  input  logic           soc_pwr_err_i,
  input  logic           on_req_i,
  input  logic           mcu_on_req_i,
  input  logic           wake1_i,
  input  logic           wake2_i,
  input  logic [1:0]     sleep_pin_i,
  input  logic [1:0]     sleep_reg_i,
  input  logic [1:0]     sleep_mask_i,
  input  logic [3:0]     cmd_set_i,
  input  logic [RCW-1:0] recov_thr_i,
  input  logic           seq_done_i,
  output logic [3:0]     state_o,
  output logic           seq_start_o,
  output logic [4:0]     seq_code_o,
  output logic           seq_busy_o,
  output logic           crc_en_o,
  output logic           bus2_hold_o,
  output logic [RCW-1:0] recov_cnt_o,
  output logic           recov_halt_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  pstate_e    state_q, state_d;
  logic       busy_q, busy_d;
  logic       start_q, start_d;
  seq_e       code_q, code_d;
  logic [3:0] pend_q, pend_d, pend_clr;
  logic       crc_q, crc_go, rec_inc, rec_reached;

  logic [1:0]       sl;
  logic             sl_en, cmd_en;
  logic [NTRIG-1:0] req;
  logic             win;
  logic [TW-1:0]    win_id;
  row_t             win_row;

  assign sl     = sleep_pin_i | sleep_reg_i;
  assign sl_en  = ~|sleep_mask_i;
  assign cmd_en = &sleep_mask_i;

  always_comb begin
    req     = '0;
    req[0]  = imm_sd_i;
    req[1]  = mcu_pwr_err_i;
    req[2]  = orderly_sd_i;
    req[4]  = off_req_i;
    req[5]  = wdog_err_i;
    req[6]  = esm_mcu_err_i;
    req[7]  = esm_soc_err_i;
    req[8]  = wdog_err_i;
    req[9]  = esm_mcu_err_i;
    req[10] = soc_pwr_err_i;
    req[11] = pend_q[1];
    req[12] = pend_q[2];
    req[13] = on_req_i;
    req[14] = wake1_i;
    req[15] = sl_en & sl[0] & sl[1];
    req[16] = mcu_on_req_i;
    req[17] = wake2_i;
    req[18] = sl_en & ~sl[0] & sl[1];
    req[19] = sl_en & ~sl[0] & ~sl[1];
    req[20] = sl_en & sl[0] & ~sl[1];
    req[21] = cmd_en & pend_q[0];
    req[22] = cmd_en & pend_q[3];
  end

  pwr_trig_arb #(.N(NTRIG), .IW(TW)) u_arb (
    .state_i (state_q),
    .busy_i  (busy_q),
    .req_i   (req),
    .win_o   (win),
    .id_o    (win_id),
    .row_o   (win_row)
  );

  pwr_recov_cnt #(.W(RCW)) u_recov (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .inc_i     (rec_inc),
    .thr_i     (recov_thr_i),
    .cnt_o     (recov_cnt_o),
    .reached_o (rec_reached)
  );

  pwr_hold_tmr #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) u_hold (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load_i   (crc_go),
    .active_o (bus2_hold_o)
  );

  always_comb begin
    state_d  = state_q;
    busy_d   = busy_q & ~seq_done_i;
    start_d  = 1'b0;
    code_d   = code_q;
    pend_clr = '0;
    crc_go   = 1'b0;
    rec_inc  = 1'b0;
    if (win) begin
      start_d = 1'b1;
      busy_d  = 1'b1;
      code_d  = win_row.code;
      if (win_row.move) state_d = win_row.dest;
      case (win_id)
        TW'(11): pend_clr[1] = 1'b1;
        TW'(12): begin pend_clr[2] = 1'b1; crc_go = 1'b1; end
        TW'(21): pend_clr[0] = 1'b1;
        TW'(22): pend_clr[3] = 1'b1;
        default: ;
      endcase
    end else if (state_q == ST_SAFE && !busy_q) begin
      state_d = ST_SAFE_REC;
      rec_inc = 1'b1;
    end else if (state_q == ST_SAFE_REC) begin
      state_d = rec_reached ? ST_HALT : ST_STANDBY;
    end
    pend_d = (pend_q & ~pend_clr) | cmd_set_i;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_STANDBY;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      code_q  <= SQ_NONE;
      pend_q  <= '0;
      crc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      code_q  <= code_d;
      pend_q  <= pend_d;
      if (crc_go) crc_q <= 1'b1;
    end
  end

  assign state_o      = state_q;
  assign seq_start_o  = start_q;
  assign seq_code_o   = code_q;
  assign seq_busy_o   = busy_q;
  assign crc_en_o     = crc_q;
  assign recov_halt_o = (state_q == ST_HALT);

endmodule

// File: rtl/pwr_trig_ctrl_chk.sv
module pwr_trig_ctrl_chk #(
  parameter int unsigned RCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [3:0]     state,
  input logic           busy,
  input logic           start,
  input logic [4:0]     code,
  input logic           hold,
  input logic [RCW-1:0] cnt
);

  // R3: a start of any safe sequence always lands in SAFE
  assert_imm_to_safe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && code inside {5'd1, 5'd2, 5'd3}) |-> state == 4'd4);

  // R4: a start that follows a busy cycle must come from an immediate row
  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(busy)) |-> code inside {5'd1, 5'd2, 5'd3});

  // R10: the bus hold only begins together with a CRC enable start
  assert_hold_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> (start && code == 5'd11));

  // R11: SAFE with no sequence running steps to SAFE_RECOVERY
  assert_safe_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd4 && !busy) |=> state == 4'd5);

  // R11: HALTED is kept until reset
  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd6 |=> state == 4'd6);

  // R11: the recovery count never goes down
  assert_cnt_mono_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= $past(cnt));

endmodule

bind pwr_trig_ctrl pwr_trig_ctrl_chk #(.RCW(RCW)) u_chk (
  .clk   (clk),
  .rst_n (rst_s_n),
  .state (state_o),
  .busy  (seq_busy_o),
  .start (seq_start_o),
  .code  (seq_code_o),
  .hold  (bus2_hold_o),
  .cnt   (recov_cnt_o)
);

// File: tb/pwr_trig_ctrl_tb.sv
module pwr_trig_ctrl_tb;

  localparam int CLK_HZ = 100_000;
  localparam int HOLD   = CLK_HZ / 1000 * 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       imm_sd, mcu_pwr, orderly, off_req, wdog, esm_mcu, esm_soc, soc_pwr;
  logic       on_req, mcu_on, wake1, wake2, seq_done;
  logic [1:0] sleep_pin, sleep_reg, sleep_mask;
  logic [3:0] cmd_set;
  logic [2:0] recov_thr;

  logic [3:0] state_o;
  logic       seq_start_o, seq_busy_o, crc_en_o, bus2_hold_o, recov_halt_o;
  logic [4:0] seq_code_o;
  logic [2:0] recov_cnt_o;

  pwr_trig_ctrl #(.CLK_HZ(CLK_HZ), .HOLD_MS(2), .RCW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .imm_sd_i(imm_sd), .mcu_pwr_err_i(mcu_pwr),
    .orderly_sd_i(orderly), .off_req_i(off_req), .wdog_err_i(wdog),
    .esm_mcu_err_i(esm_mcu), .esm_soc_err_i(esm_soc), .soc_pwr_err_i(soc_pwr),
    .on_req_i(on_req), .mcu_on_req_i(mcu_on), .wake1_i(wake1), .wake2_i(wake2),
    .sleep_pin_i(sleep_pin), .sleep_reg_i(sleep_reg), .sleep_mask_i(sleep_mask),
    .cmd_set_i(cmd_set), .recov_thr_i(recov_thr), .seq_done_i(seq_done),
    .state_o(state_o), .seq_start_o(seq_start_o), .seq_code_o(seq_code_o),
    .seq_busy_o(seq_busy_o), .crc_en_o(crc_en_o), .bus2_hold_o(bus2_hold_o),
    .recov_cnt_o(recov_cnt_o), .recov_halt_o(recov_halt_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int m_state, m_code, m_hold, m_cnt;
  bit m_busy, m_start, m_crc;
  bit [3:0] m_pend;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Row table as stated in the requirements (R3, R5-R9).
  function automatic void m_row(int id, int s, output bit ok, output bit mv,
                                output int d, output int c, output bit im);
    bit norm = s inside {0, 1, 2, 3};
    ok = 0; mv = 0; d = s; c = 0; im = 0;
    case (id)
      0: begin ok = norm; mv = 1; d = 4; c = 1; im = 1; end
      1: begin ok = norm; mv = 1; d = 4; c = 2; im = 1; end
      2: begin ok = norm; mv = 1; d = 4; c = 3; im = 1; end
      4: begin ok = s inside {1, 2, 3, 7}; mv = 1; d = 0; c = 4; end
      5, 6: begin ok = (s == 1); c = 5; end
      7: begin ok = (s == 1); c = 6; end
      8: begin ok = (s == 2); c = 7; end
      9: begin ok = (s == 2); c = 8; end
      10: begin ok = (s == 1); mv = 1; d = 7; c = 9; end
      11: begin ok = s inside {1, 2}; c = 10; end
      12: begin ok = s inside {1, 2}; c = 11; end
      13, 14, 15: begin ok = s inside {0, 2, 3, 8}; mv = 1; d = 1; c = 12; end
      16, 17: begin ok = s inside {0, 1, 3, 8}; mv = 1; d = 2; c = 13; end
      18: begin ok = s inside {1, 3}; mv = 1; d = 2; c = 13; end
      19, 20: begin ok = s inside {1, 2}; mv = 1; d = 3; c = 14; end
      21: begin ok = s inside {0, 1, 2}; mv = 1; d = 8; c = 16; end
      22: begin ok = s inside {1, 2}; c = 15; end
      default: ;
    endcase
  endfunction

  task automatic model_step();
    bit [1:0] sl;
    bit slen, cmden, ok, mv, im, wmv, crcgo, inc;
    bit [22:0] rq;
    bit [3:0] clr;
    int win, d, c, wd, wc, ns;
    sl = sleep_pin | sleep_reg;
    slen = (sleep_mask == 2'b00);
    cmden = (sleep_mask == 2'b11);
    rq = '0;
    rq[0] = imm_sd; rq[1] = mcu_pwr; rq[2] = orderly; rq[4] = off_req;
    rq[5] = wdog; rq[6] = esm_mcu; rq[7] = esm_soc; rq[8] = wdog; rq[9] = esm_mcu;
    rq[10] = soc_pwr; rq[11] = m_pend[1]; rq[12] = m_pend[2]; rq[13] = on_req;
    rq[14] = wake1; rq[15] = slen && sl == 2'b11; rq[16] = mcu_on; rq[17] = wake2;
    rq[18] = slen && sl == 2'b10; rq[19] = slen && sl == 2'b00; rq[20] = slen && sl == 2'b01;
    rq[21] = cmden && m_pend[0]; rq[22] = cmden && m_pend[3];
    win = -1; wd = 0; wc = 0; wmv = 0;
    for (int i = 0; i < 23; i++) begin
      if (win < 0) begin
        m_row(i, m_state, ok, mv, d, c, im);
        if (rq[i] && ok && (im || !m_busy)) begin win = i; wd = d; wc = c; wmv = mv; end
      end
    end
    clr = '0; crcgo = 0; inc = 0; ns = m_state;
    m_start = 0;
    if (win >= 0) begin
      m_start = 1; m_code = wc;
      if (wmv) ns = wd;
      case (win)
        11: clr[1] = 1;
        12: begin clr[2] = 1; crcgo = 1; end
        21: clr[0] = 1;
        22: clr[3] = 1;
        default: ;
      endcase
      m_busy = 1;
    end else begin
      if (seq_done) m_busy = 0;
      if (m_state == 4 && !m_busy && !seq_done) begin ns = 5; inc = 1; end
      else if (m_state == 4 && m_busy == 0 && seq_done) ns = ns; // placeholder keeps order
    end
    m_state = ns;
    if (crcgo) begin m_crc = 1; m_hold = HOLD; end
    else if (m_hold > 0) m_hold--;
    if (inc && m_cnt < 7) m_cnt++;
    m_pend = (m_pend & ~clr) | cmd_set;
  endtask

  // busy before the edge is needed for the SAFE exit; keep a copy
  bit busy_pre;
  int state_pre;
  task automatic tick();
    @(posedge clk);
    busy_pre = m_busy;
    state_pre = m_state;
    model_step_fix();
    @(negedge clk);
    chk("R2 state", state_o, m_state);
    chk("R2 start", seq_start_o, m_start);
    chk("R2 code", seq_code_o, m_code);
    chk("R4 busy", seq_busy_o, m_busy);
    chk("R10 crc", crc_en_o, m_crc);
    chk("R10 hold", bus2_hold_o, m_hold > 0);
    chk("R11 count", recov_cnt_o, m_cnt);
    chk("R11 halt", recov_halt_o, m_state == 6);
  endtask

  // SAFE and SAFE_RECOVERY handling uses the busy value from before the edge.
  task automatic model_step_fix();
    int s0, c0;
    bit b0;
    s0 = m_state; b0 = m_busy; c0 = m_cnt;
    model_step();
    if (!m_start) begin
      if (s0 == 4 && !b0) begin m_state = 5; if (c0 < 7) m_cnt = c0 + 1; else m_cnt = c0; end
      else if (s0 == 4) m_state = 4;
      else if (s0 == 5) m_state = (c0 >= recov_thr) ? 6 : 0;
    end
  endtask

  task automatic idle();
    imm_sd = 0; mcu_pwr = 0; orderly = 0; off_req = 0; wdog = 0; esm_mcu = 0;
    esm_soc = 0; soc_pwr = 0; on_req = 0; mcu_on = 0; wake1 = 0; wake2 = 0;
    seq_done = 0; sleep_pin = 0; sleep_reg = 0; sleep_mask = 2'b01; cmd_set = 0;
  endtask

  task automatic do_reset(input logic [2:0] thr);
    idle();
    recov_thr = thr;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_state = 0; m_code = 0; m_hold = 0; m_cnt = 0;
    m_busy = 0; m_start = 0; m_crc = 0; m_pend = 0;
  endtask

  task automatic done1();
    seq_done = 1; tick(); seq_done = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    do_reset(3'd2);
    // R1 reset state
    chk("R1 state", state_o, 0); chk("R1 start", seq_start_o, 0);
    chk("R1 busy", seq_busy_o, 0); chk("R1 crc", crc_en_o, 0);
    chk("R1 hold", bus2_hold_o, 0); chk("R1 count", recov_cnt_o, 0);

    // R7 sleep controls drive ACTIVE, MCU_ONLY, RETENTION
    sleep_mask = 2'b00; sleep_pin = 2'b11; tick();
    chk("R7 both high", state_o, 1); chk("R7 code", seq_code_o, 12);
    done1();
    sleep_pin = 2'b10; tick(); chk("R7 sleep1 low", state_o, 2);
    done1();
    sleep_pin = 2'b00; sleep_reg = 2'b01; tick();
    chk("R7 reg bit OR", state_o, 3); chk("R7 code ret", seq_code_o, 14);
    // R3 immediate pre-emption while busy, R2 lowest ID wins
    imm_sd = 1; mcu_pwr = 1; tick();
    chk("R3 to safe", state_o, 4); chk("R2 priority", seq_code_o, 1);
    imm_sd = 0; mcu_pwr = 0;
    done1(); chk("R11 safe wait", state_o, 4);
    tick(); chk("R11 recovery", state_o, 5); chk("R11 count", recov_cnt_o, 1);
    tick(); chk("R11 below thr", state_o, 0);

    // R8/R9 masked command 0
    do_reset(3'd2);
    wake1 = 1; tick(); wake1 = 0; done1();
    cmd_set = 4'b0001; tick(); cmd_set = 0;
    repeat (3) tick();
    chk("R8 partial mask", state_o, 1); chk("R8 no start", seq_start_o, 0);
    sleep_mask = 2'b11; tick();
    chk("R9 to low power", state_o, 8); chk("R9 code", seq_code_o, 16);
    done1(); sleep_mask = 2'b01;
    // R10 CRC hold
    wake1 = 1; tick(); wake1 = 0; done1();
    cmd_set = 4'b0100; tick(); cmd_set = 0; tick();
    chk("R9 no move", state_o, 1); chk("R10 code", seq_code_o, 11);
    chk("R10 crc on", crc_en_o, 1);
    begin
      int hc = 0;
      while (bus2_hold_o && hc < HOLD + 10) begin hc++; tick(); end
      chk("R10 hold length", hc, HOLD);
    end

    // R5 re-entrant, R4 busy blocks
    do_reset(3'd2);
    wake1 = 1; tick(); wake1 = 0; done1();
    wdog = 1; tick(); wdog = 0;
    chk("R5 stay active", state_o, 1); chk("R5 code", seq_code_o, 5);
    mcu_on = 1; tick(); chk("R4 blocked", seq_start_o, 0); chk("R4 state", state_o, 1);
    done1(); chk("R4 done edge", seq_start_o, 0);
    tick(); chk("R4 after done", state_o, 2); mcu_on = 0;

    // R6 SoC error and off request
    do_reset(3'd2);
    wake1 = 1; tick(); wake1 = 0; done1();
    soc_pwr = 1; tick(); soc_pwr = 0;
    chk("R6 soc err", state_o, 7); chk("R6 code", seq_code_o, 9);
    done1(); off_req = 1; tick(); off_req = 0;
    chk("R6 off", state_o, 0);

    // R11 halt at threshold
    do_reset(3'd1);
    imm_sd = 1; tick(); imm_sd = 0;
    done1(); tick(); tick();
    chk("R11 halted", recov_halt_o, 1);
    wake1 = 1; tick(); wake1 = 0; chk("R11 stays halted", state_o, 6);

    // constrained random against the model
    for (int ph = 0; ph < 6; ph++) begin
      do_reset(3'(1 + $urandom(ph + 7) % 7));
      for (int k = 0; k < 2500; k++) begin
        imm_sd = ($urandom % 300) == 0; mcu_pwr = ($urandom % 300) == 0;
        orderly = ($urandom % 300) == 0; off_req = ($urandom % 40) == 0;
        wdog = ($urandom % 12) == 0; esm_mcu = ($urandom % 12) == 0;
        esm_soc = ($urandom % 12) == 0; soc_pwr = ($urandom % 60) == 0;
        on_req = ($urandom % 10) == 0; mcu_on = ($urandom % 10) == 0;
        wake1 = ($urandom % 10) == 0; wake2 = ($urandom % 10) == 0;
        seq_done = ($urandom % 3) == 0;
        cmd_set = 4'(($urandom % 8) == 0 ? (1 << ($urandom % 4)) : 0);
        if (($urandom % 20) == 0) begin
          sleep_pin = 2'($urandom); sleep_reg = 2'($urandom); sleep_mask = 2'($urandom);
        end
        tick();
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule